// File: doc/BRIEF.md
# Four-Channel Multiphase-Sampling Time-to-Digital Converter

This block timestamps rising edges on four logic-level inputs with a resolution of one quarter of the reference clock period. Each input is captured by four flip-flops. Each flip-flop is clocked by one of four copies of the reference clock, and the copies are spaced a quarter period apart. The four samples from one reference period form a window. The window is moved into the reference domain, which is the 0-degree phase, and is compared with the last sample of the previous window.

The first low-to-high step in the window gives a 2-bit fine code. A free-running coarse counter, shared by all channels, supplies the upper bits. The resulting timestamp counts quarter-period ticks since the last reset edge, modulo the width of the stamp. It is presented with a one-cycle valid strobe.

A typical use places the block behind comparators that turn analog crossings into logic edges. A downstream collector then captures the valid strobe and the stamp of each channel.

Top module: `mps_tdc`

## Requirements
- R1: A reference edge with `rst` high clears every valid strobe and every stamp to zero. The window that opens at the last reset edge is window 0, with coarse value 0.
- R2: Sample i of a window (i = 0..3) is taken i quarter periods after the window's opening reference edge, on phase 0, 90, 180 and 270 degrees in that order. The fine code is the index i of the first sample that is high while the sample before it is low.
- R3: The stamp is {coarse, fine}, with coarse in the upper CW bits and fine in the low 2 bits. Coarse is the number of reference edges from the last reset edge to the window's opening edge. So the stamp equals 4 × window + fine, which is the tick of the first high sample.
- R4: The valid strobe and stamp for a window that opens at reference edge k appear after reference edge k+2. They stay for one cycle unless the next window reports its own edge.
- R5: A falling edge, or an input held steadily high or low, produces no valid strobe.
- R6: When a window holds more than one rising step, only the earliest is reported and the later ones are dropped.
- R7: The first sample of a window is compared with the last sample of the previous window. Rising edges in consecutive windows therefore give valid strobes in consecutive cycles.
- R8: The channels are independent. Simultaneous edges on several channels are all reported, each against the same shared coarse counter.
- R9: The coarse field wraps modulo 2^CW. The stamp after the all-ones value of the coarse field restarts from a coarse value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p0 | input | 1 | Reference clock, phase 0 degrees; all results are in this domain |
| clk_p90 | input | 1 | Same clock delayed by a quarter period |
| clk_p180 | input | 1 | Same clock delayed by half a period |
| clk_p270 | input | 1 | Same clock delayed by three quarters of a period |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| hit_in | input | NCH | Logic-level inputs to be timestamped, one per channel |
| ts_valid | output | NCH | One-cycle strobe per channel marking a new stamp |
| ts_stamp | output | NCH*(CW+2) | Packed stamps; channel c occupies bits c*(CW+2) upward |

## Verification
Two functions can act in the same reference cycle: the coarse counter rolling over to zero, and the encoder reporting a hit. The bench waits for the window whose coarse value is all ones. It places one edge in the last quarter of that window and a second edge, on another channel, at the first sample of the next window. The second window's fine code comes from the cross-window comparison. The judgement is that the stamps read all-ones followed by exactly zero, with each strobe in the cycle that the two-stage latency predicts. Simultaneous edges on all four channels, whose offsets straddle a window boundary, are also checked against a single coarse count.

// File: rtl/mps_tdc_pkg.sv
package mps_tdc_pkg;

    localparam int NPH = 4;
    localparam int FW  = $clog2(NPH);

    // One reference period of samples plus the last sample of the period before.
    typedef struct packed {
        logic [NPH-1:0] smp;   // smp[i] taken i quarter periods after the opening edge
        logic           prev;  // last sample of the preceding window
    } win_t;

    typedef struct packed {
        logic          hit;
        logic [FW-1:0] fine;
    } rise_t;

    // Earliest low-to-high step in time order; later steps are overridden.
    function automatic rise_t first_rise(win_t w);
        rise_t          r;
        logic [NPH:0]   seq;
        r   = '0;
        seq = {w.smp, w.prev};
        for (int i = NPH - 1; i >= 0; i--) begin
            if (seq[i+1] && !seq[i]) begin
                r.hit  = 1'b1;
                r.fine = FW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mps_phase_sampler.sv
module mps_phase_sampler
    import mps_tdc_pkg::*;
(
    input  logic [NPH-1:0] clk_ph,
    input  logic           din,
    output logic [NPH-1:0] smp
);

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        logic q;
        always_ff @(posedge clk_ph[g]) begin
            q <= din;
        end
        assign smp[g] = q;
    end

endmodule

// File: rtl/mps_aligner.sv
module mps_aligner
    import mps_tdc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] smp_in,
    output win_t           win
);

    // All phase samples of the period just ended are stable at this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else begin
            win.smp  <= smp_in;
            win.prev <= win.smp[NPH-1];
        end
    end

endmodule

// File: rtl/mps_coarse_counter.sv
module mps_coarse_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_lag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            count_lag <= '0;
        end else begin
            count     <= count + CW'(1);
            count_lag <= count;
        end
    end

endmodule

// File: rtl/mps_edge_encoder.sv
module mps_edge_encoder
    import mps_tdc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  win_t             win,
    input  logic [CW-1:0]    coarse,
    output logic             valid,
    output logic [CW+FW-1:0] stamp
);

    rise_t rise;

    always_comb begin
        rise = first_rise(win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            stamp <= '0;
        end else begin
            valid <= rise.hit;
            if (rise.hit) begin
                stamp <= {coarse, rise.fine};
            end
        end
    end

endmodule

// File: rtl/mps_tdc.sv
module mps_tdc
    import mps_tdc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8
) (
    input  logic                     clk_p0,
    input  logic                     clk_p90,
    input  logic                     clk_p180,
    input  logic                     clk_p270,
    input  logic                     rst,
    input  logic [NCH-1:0]           hit_in,
    output logic [NCH-1:0]           ts_valid,
    output logic [NCH*(CW+FW)-1:0]   ts_stamp
);

    localparam int TW = CW + FW;
    localparam int WW = $bits(win_t);

    logic [NPH-1:0]     clk_ph;
    logic [CW-1:0]      coarse_now;
    logic [CW-1:0]      coarse_lag;
    logic [NCH*WW-1:0]  win_flat;

    assign clk_ph = {clk_p270, clk_p180, clk_p90, clk_p0};

    mps_coarse_counter #(.CW(CW)) u_coarse (
        .clk       (clk_p0),
        .rst       (rst),
        .count     (coarse_now),
        .count_lag (coarse_lag)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NPH-1:0] smp;
        win_t           win;

        mps_phase_sampler u_sampler (
            .clk_ph (clk_ph),
            .din    (hit_in[c]),
            .smp    (smp)
        );

        mps_aligner u_align (
            .clk    (clk_p0),
            .rst    (rst),
            .smp_in (smp),
            .win    (win)
        );

        mps_edge_encoder #(.CW(CW)) u_enc (
            .clk    (clk_p0),
            .rst    (rst),
            .win    (win),
            .coarse (coarse_lag),
            .valid  (ts_valid[c]),
            .stamp  (ts_stamp[c*TW +: TW])
        );

        assign win_flat[c*WW +: WW] = win;
    end

endmodule

// File: rtl/mps_tdc_chk.sv
module mps_tdc_chk
    import mps_tdc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NCH*(NPH+1)-1:0]       win_flat,
    input logic [CW-1:0]                coarse,
    input logic [NCH-1:0]               ts_valid,
    input logic [NCH*(CW+FW)-1:0]       ts_stamp
);

    localparam int TW = CW + FW;
    localparam int WW = NPH + 1;

    logic [NCH*WW-1:0] win_q;

    always_ff @(posedge clk) begin
        win_q <= win_flat;
    end

    // R3 R9
    coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> coarse == CW'($past(coarse) + CW'(1)));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R5
        hit_has_rise_chk: assert property (@(posedge clk) disable iff (rst)
            ts_valid[c] |-> ($past(win_flat[c*WW +: WW]) != '0 &&
                             $past(win_flat[c*WW +: WW]) != '1));

        // R2
        fine_points_high_chk: assert property (@(posedge clk) disable iff (rst)
            ts_valid[c] |-> win_q[c*WW + 1 + int'(ts_stamp[c*TW +: FW])]);

        // R4
        coarse_latency_chk: assert property (@(posedge clk) disable iff (rst)
            ts_valid[c] |-> ts_stamp[c*TW + FW +: CW] == $past(coarse, 2));
    end

endmodule

bind mps_tdc mps_tdc_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk_p0),
    .rst      (rst),
    .win_flat (win_flat),
    .coarse   (coarse_now),
    .ts_valid (ts_valid),
    .ts_stamp (ts_stamp)
);

// File: tb/mps_tdc_bench.sv
`timescale 1ns/1ps
module mps_tdc_bench;

    localparam int     NCH = 4;
    localparam int     CW  = 8;
    localparam int     TW  = CW + 2;
    localparam longint MOD = longint'(1) << TW;

    logic clk_p0 = 1'b0, clk_p90 = 1'b0, clk_p180 = 1'b0, clk_p270 = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]    hit_in = '0;
    logic [NCH-1:0]    ts_valid;
    logic [NCH*TW-1:0] ts_stamp;

    int     errors = 0;
    int     checks = 0;
    longint t0 = 0;
    bit     done = 0;

    // 125 MHz, phases 2 ns apart
    always #4 clk_p0 = ~clk_p0;
    initial begin #2; forever #4 clk_p90  = ~clk_p90;  end
    initial begin #4; forever #4 clk_p180 = ~clk_p180; end
    initial begin #6; forever #4 clk_p270 = ~clk_p270; end

    mps_tdc #(.NCH(NCH), .CW(CW)) u_mps_tdc (
        .clk_p0   (clk_p0),
        .clk_p90  (clk_p90),
        .clk_p180 (clk_p180),
        .clk_p270 (clk_p270),
        .rst      (rst),
        .hit_in   (hit_in),
        .ts_valid (ts_valid),
        .ts_stamp (ts_stamp)
    );

    task automatic at(input longint t);
        if (t > longint'($time)) #(t - longint'($time));
    endtask

    function automatic longint obs_time(input longint w);
        return t0 + 8 * w + 1;
    endfunction

    function automatic longint next_k();
        return (longint'($time) - t0) / 8 + 2;
    endfunction

    function automatic longint stamp_of(input int c);
        return longint'(ts_stamp[c*TW +: TW]);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // result of window w is visible after reference edge w+2
    task automatic expect_hit(input string req, input int c, input longint w, input longint n);
        at(obs_time(w + 2));
        check({req, " valid"}, longint'(ts_valid[c]), 1);
        check({req, " stamp"}, stamp_of(c), n % MOD);
    endtask

    task automatic expect_quiet(input string req, input int c, input longint w);
        at(obs_time(w + 2));
        check({req, " no valid"}, longint'(ts_valid[c]), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk_p0);
        t0 = longint'($time);
        #1 rst = 1'b0;
        // R1
        check("R1 valid after reset", longint'(ts_valid), 0);
        check("R1 stamps after reset", longint'(ts_stamp), 0);
    endtask

    task automatic t_phases();
        for (int i = 0; i < 4; i++) begin
            longint k = next_k();
            longint n = 4 * k + i + 1;
            longint w = n / 4;
            at(t0 + 8 * k + 2 * i + 1);
            hit_in[0] = 1'b1;
            expect_quiet("R4 not early", 0, w - 1);
            expect_hit("R2 R3 phase", 0, w, n);
            expect_quiet("R5 steady high", 0, w + 1);
            hit_in[0] = 1'b0;
            expect_quiet("R5 falling edge", 0, w + 3);
            expect_quiet("R5 steady low", 0, w + 4);
        end
    endtask

    task automatic t_channels();
        longint k = next_k();
        for (int c = 0; c < NCH; c++) begin
            at(t0 + 8 * k + 2 * c + 1);
            hit_in[c] = 1'b1;
        end
        // R8: offsets 1,3,5 fall in window k, offset 7 in window k+1
        at(obs_time(k + 2));
        for (int c = 0; c < 3; c++) begin
            check("R8 channel valid", longint'(ts_valid[c]), 1);
            check("R8 channel stamp", stamp_of(c), (4 * k + c + 1) % MOD);
        end
        check("R8 late channel quiet", longint'(ts_valid[3]), 0);
        at(obs_time(k + 3));
        check("R8 late channel valid", longint'(ts_valid[3]), 1);
        check("R8 late channel stamp", stamp_of(3), (4 * k + 4) % MOD);
        check("R8 early channels quiet", longint'(ts_valid[2:0]), 0);
        hit_in = '0;
        at(obs_time(k + 6));
    endtask

    task automatic t_double();
        longint k = next_k();
        at(t0 + 8 * k + 1); hit_in[1] = 1'b1;
        at(t0 + 8 * k + 3); hit_in[1] = 1'b0;
        at(t0 + 8 * k + 5); hit_in[1] = 1'b1;
        // R6: only the first step (tick 4k+1) counts
        expect_hit("R6 first step", 1, k, 4 * k + 1);
        expect_quiet("R6 second step dropped", 1, k + 1);
        hit_in[1] = 1'b0;
        at(obs_time(k + 6));
    endtask

    task automatic t_back_to_back();
        longint k = next_k();
        at(t0 + 8 * k + 5);  hit_in[2] = 1'b1;
        at(t0 + 8 * k + 9);  hit_in[2] = 1'b0;
        at(t0 + 8 * k + 15); hit_in[2] = 1'b1;
        // R7: second rise at tick 4k+8 is phase 0 of window k+2, compared with window k+1
        expect_hit("R7 first window", 2, k, 4 * k + 3);
        expect_quiet("R7 low window", 2, k + 1);
        expect_hit("R7 cross-boundary", 2, k + 2, 4 * k + 8);
        hit_in[2] = 1'b0;
        at(obs_time(k + 6));
    endtask

    task automatic t_wrap();
        longint b = next_k();
        longint k = b + ((255 - (b % 256)) + 256) % 256;
        at(t0 + 8 * k + 5); hit_in[1] = 1'b1;
        at(t0 + 8 * k + 7); hit_in[3] = 1'b1;
        // R9: coarse 255 then 0
        expect_hit("R9 last count", 1, k, 4 * k + 3);
        check("R9 all-ones stamp", stamp_of(1), MOD - 1);
        expect_hit("R9 wrapped count", 3, k + 1, 4 * k + 4);
        check("R9 wrapped stamp", stamp_of(3), 0);
        hit_in = '0;
        at(obs_time(k + 5));
    endtask

    initial begin
        t_reset();
        t_phases();
        t_channels();
        t_double();
        t_back_to_back();
        t_wrap();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule